// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a watchdog that must be serviced inside a time window, not merely before a deadline. Software sets it up through a small register port with a plain single-cycle read/write bus. Once enabled, one down-counter first runs a closed window loaded from one 32-bit register. It then runs an open window loaded from a second 32-bit register. When the closed window ends, the block raises an interrupt as an early warning. If the open window ends without service, it emits a one-cycle reset pulse and stops.

Service is only legal in the open window. Any attempt to refresh, stop or reconfigure during the closed window is dropped. Every write except to the unlock register first needs a one-shot unlock. Leaving the pre-warning out is done by loading zero as the closed length and the full timeout as the open length.

The controller has three states. IDLE means disabled. CLOSED means enabled in the first window. OPEN means enabled in the second window. The transitions are:
- start: IDLE to CLOSED, on an enable write.
- warn: CLOSED to OPEN, when the closed count runs out. The interrupt is raised here.
- refresh: OPEN to CLOSED, on an armed service write.
- stop: OPEN to IDLE, on a disable write.
- expire: OPEN to IDLE, when the open count runs out. The reset pulse is emitted here.

Top module: `window_watchdog`

## Requirements
- R1: After reset every mapped register reads 0, and both `irq` and `rst_pulse` are low. The mapped byte offsets are 0x00 unlock, 0x04 control/status, 0x08 function control, 0x0C closed-window length and 0x10 open-window length.
- R2: A write to any offset other than 0x00 has no effect unless unlock bit 0 at 0x00 is 1.
- R3: The unlock bit reads back at 0x00 bit 0. It clears itself after one accepted write to another mapped offset.
- R4: Writing 1 to control bit 0 while disabled starts the closed window. For N cycles after the write, status reads enable bit 0 = 1 and window bit 8 = 0, where N is the value of the closed-window length register.
- R5: One cycle later the block enters the open window. From then on `irq` and status bit 16 read 1 and status bit 8 reads 1.
- R6: After the open window has held for M+1 cycles, with M the open-window length, `rst_pulse` is high for exactly one cycle. The block then reads as disabled and raises no further interrupt or reset until it is re-enabled.
- R7: During the closed window, writes to control, closed-window length and open-window length are ignored, including an attempt to stop.
- R8: In the open window a refresh takes two writes. The first has bit 0 = 1 and bit 8 = 0, which arms the refresh. The second has bit 0 = 1 and bit 8 = 1, which restarts the closed window.
- R9: Writing 0 to control bit 0 in the open window stops the timer. No reset pulse follows.
- R10: Writing 1 to status bit 16 while the block is not in the closed window clears the interrupt flag and `irq`.
- R11: The function-control register at 0x08 stores and reads back 32 bits. Reads of unmapped offsets return 0.
- R12: A write with bit 8 = 1 in the open window that is not preceded by an arming write does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Early-warning interrupt (level) |
| rst_pulse | output | 1 | One-cycle reset request |

## Verification
Most faults in this block show at the ports quickly.

A wrong window state shows in the status register on the very next read. It also moves the `irq` edge or the `rst_pulse` cycle away from the count of N+1 or M+1 cycles after the last control write.

A counter that is off by one shifts these events by one cycle. Sampling at the exact cycle boundary catches that shift.

A gate that lets a write through in the wrong window, or keeps the unlock bit set, shows as a changed readback or a state change right after that write.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
    localparam int BUS_W = 32;

    // byte offsets of the register port
    localparam int OFF_UNLOCK = 8'h00;
    localparam int OFF_CTRL   = 8'h04;
    localparam int OFF_FCR    = 8'h08;
    localparam int OFF_WIN1   = 8'h0C;
    localparam int OFF_WIN2   = 8'h10;

    // control/status bit positions
    localparam int BIT_EN  = 0;
    localparam int BIT_SW  = 8;
    localparam int BIT_IRQ = 16;

    typedef enum logic [1:0] {
        WST_IDLE   = 2'd0,
        WST_CLOSED = 2'd1,
        WST_OPEN   = 2'd2
    } wst_e;
endpackage

// File: rtl/wwd_regs.sv
module wwd_regs
    import wwd_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              open_win,
    input  logic              stat_en,
    input  logic              stat_sw,
    input  logic              stat_irq,
    output logic [CNT_W-1:0]  win1_q,
    output logic [CNT_W-1:0]  win2_q,
    output logic              unlock_q,
    output logic              acc_we,
    output logic              ctl_we
);
    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_FCR    = ADDR_W'(OFF_FCR);
    localparam logic [ADDR_W-1:0] A_WIN1   = ADDR_W'(OFF_WIN1);
    localparam logic [ADDR_W-1:0] A_WIN2   = ADDR_W'(OFF_WIN2);

    logic [BUS_W-1:0] fcr_q;
    logic             wr_unlock;
    logic             mapped;

    assign wr_unlock = bus_sel && bus_wr && (bus_addr == A_UNLOCK);
    assign mapped    = (bus_addr == A_CTRL) || (bus_addr == A_FCR) ||
                       (bus_addr == A_WIN1) || (bus_addr == A_WIN2);
    // a write is taken only when unlocked and outside the closed window
    assign acc_we    = bus_sel && bus_wr && mapped && unlock_q && open_win;
    assign ctl_we    = acc_we && (bus_addr == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
            fcr_q    <= '0;
            win1_q   <= '0;
            win2_q   <= '0;
        end else begin
            if (wr_unlock)   unlock_q <= bus_wdata[0];
            else if (acc_we) unlock_q <= 1'b0;
            if (acc_we && bus_addr == A_FCR)  fcr_q  <= bus_wdata;
            if (acc_we && bus_addr == A_WIN1) win1_q <= bus_wdata[CNT_W-1:0];
            if (acc_we && bus_addr == A_WIN2) win2_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                A_UNLOCK: bus_rdata = BUS_W'(unlock_q);
                A_CTRL:   bus_rdata = BUS_W'({stat_irq, 7'b0, stat_sw, 7'b0, stat_en});
                A_FCR:    bus_rdata = fcr_q;
                A_WIN1:   bus_rdata = BUS_W'(win1_q);
                A_WIN2:   bus_rdata = BUS_W'(win2_q);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wwd_fsm.sv
module wwd_fsm
    import wwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic             ctl_sw,
    input  logic             ctl_clr,
    input  logic [CNT_W-1:0] win1,
    input  logic [CNT_W-1:0] win2,
    output wst_e             state,
    output logic             irq_q,
    output logic             rst_q
);
    wst_e             nxt;
    logic [CNT_W-1:0] cnt;
    logic             arm_q;
    logic             cnt_zero;
    logic             do_start, do_stop, do_arm, do_restart, expire;

    assign cnt_zero   = (cnt == '0);
    assign do_start   = ctl_we && (state == WST_IDLE) && ctl_en;
    assign do_stop    = ctl_we && (state == WST_OPEN) && !ctl_en;
    assign do_arm     = ctl_we && (state == WST_OPEN) && ctl_en && !ctl_sw;
    assign do_restart = ctl_we && (state == WST_OPEN) && ctl_en && ctl_sw && arm_q;
    assign expire     = (state == WST_OPEN) && cnt_zero && !do_stop && !do_restart;

    always_comb begin
        nxt = state;
        unique case (state)
            WST_IDLE:   if (do_start) nxt = WST_CLOSED;
            WST_CLOSED: if (cnt_zero) nxt = WST_OPEN;
            WST_OPEN: begin
                if (do_stop)         nxt = WST_IDLE;
                else if (do_restart) nxt = WST_CLOSED;
                else if (cnt_zero)   nxt = WST_IDLE;
            end
            default:    nxt = WST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            arm_q <= 1'b0;
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            if (do_start || do_restart)                   cnt <= win1;
            else if (state == WST_CLOSED)                 cnt <= cnt_zero ? win2 : cnt - 1'b1;
            else if (state == WST_OPEN && !cnt_zero)      cnt <= cnt - 1'b1;
            arm_q <= (nxt == WST_OPEN) && (arm_q || do_arm);
            if (state == WST_CLOSED && cnt_zero)          irq_q <= 1'b1;
            else if (ctl_we && ctl_clr)                   irq_q <= 1'b0;
            rst_q <= expire;
        end
    end
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wwd_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_pulse
);
    wst_e             st;
    logic [CNT_W-1:0] win1_q, win2_q;
    logic             unlock_q, acc_we, ctl_we;

    wwd_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .open_win (st != WST_CLOSED),
        .stat_en  (st != WST_IDLE),
        .stat_sw  (st == WST_OPEN),
        .stat_irq (irq),
        .win1_q   (win1_q),
        .win2_q   (win2_q),
        .unlock_q (unlock_q),
        .acc_we   (acc_we),
        .ctl_we   (ctl_we)
    );

    wwd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_we (ctl_we),
        .ctl_en (bus_wdata[BIT_EN]),
        .ctl_sw (bus_wdata[BIT_SW]),
        .ctl_clr(bus_wdata[BIT_IRQ]),
        .win1   (win1_q),
        .win2   (win2_q),
        .state  (st),
        .irq_q  (irq),
        .rst_q  (rst_pulse)
    );
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker
    import wwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             rst_pulse,
    input wst_e             state,
    input logic [CNT_W-1:0] win1,
    input logic [CNT_W-1:0] win2,
    input logic             unlock,
    input logic             acc_we
);
    a_r3_unlock_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |=> !unlock);

    a_r5_irq_on_open_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == WST_CLOSED) && state == WST_OPEN) |-> irq);

    a_r6_pulse_after_open: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (state == WST_IDLE && $past(state == WST_OPEN)));

    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    a_r7_no_stop_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WST_CLOSED) |=> (state != WST_IDLE));

    a_r7_cfg_frozen_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == WST_CLOSED) |-> ($stable(win1) && $stable(win2)));
endmodule

bind window_watchdog wwd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .rst_pulse(rst_pulse),
    .state    (st),
    .win1     (win1_q),
    .win2     (win2_q),
    .unlock   (unlock_q),
    .acc_we   (acc_we)
);

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_pulse;
    int          checks = 0;
    int          errors = 0;
    int          rst_seen = 0;

    always #10 clk = ~clk;

    window_watchdog u_window_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_pulse(rst_pulse)
    );

    always @(negedge clk) if (rst_pulse) rst_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic unl_write(input logic [4:0] a, input logic [31:0] d);
        bus_write(5'h00, 32'h1);
        bus_write(a, d);
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] stat(input bit i, input bit sw, input bit en);
        return (32'(i) << 16) | (32'(sw) << 8) | 32'(en);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        for (int k = 0; k < 5; k++) begin
            bus_read(5'(4 * k), d);
            chk("R1 reg after reset", d, 32'h0);
        end
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 rst_pulse after reset", 32'(rst_pulse), 32'h0);
    endtask

    task automatic t_gating();
        logic [31:0] d;
        bus_write(5'h0C, 32'h7);
        bus_read(5'h0C, d);  chk("R2 locked write ignored", d, 32'h0);
        bus_write(5'h00, 32'h1);
        bus_read(5'h00, d);  chk("R3 unlock reads back", d, 32'h1);
        bus_write(5'h0C, 32'h9);
        bus_read(5'h0C, d);  chk("R3 unlocked write taken", d, 32'h9);
        bus_read(5'h00, d);  chk("R3 unlock self-clears", d, 32'h0);
        unl_write(5'h08, 32'hA5A5_0F0F);
        bus_read(5'h08, d);  chk("R11 fcr readback", d, 32'hA5A5_0F0F);
        bus_read(5'h14, d);  chk("R11 unmapped 0x14", d, 32'h0);
        bus_read(5'h1C, d);  chk("R11 unmapped 0x1C", d, 32'h0);
    endtask

    task automatic t_expire();
        logic [31:0] d;
        int base;
        unl_write(5'h0C, 32'd5);
        unl_write(5'h10, 32'd6);
        base = rst_seen;
        unl_write(5'h04, 32'h1);
        bus_read(5'h04, d);  chk("R4 closed after start", d, stat(0, 0, 1));
        tick(5);
        chk("R4 irq low through closed", 32'(irq), 32'h0);
        bus_read(5'h04, d);  chk("R4 last closed cycle", d, stat(0, 0, 1));
        tick(1);
        chk("R5 irq at open entry", 32'(irq), 32'h1);
        bus_read(5'h04, d);  chk("R5 status open", d, stat(1, 1, 1));
        tick(6);
        chk("R6 no pulse yet", 32'(rst_pulse), 32'h0);
        tick(1);
        chk("R6 pulse high", 32'(rst_pulse), 32'h1);
        tick(1);
        chk("R6 pulse one cycle", 32'(rst_pulse), 32'h0);
        bus_read(5'h04, d);  chk("R6 disabled after expiry", d, stat(1, 0, 0));
        tick(50);
        chk("R6 halted no more pulses", 32'(rst_seen - base), 32'd1);
        bus_read(5'h04, d);  chk("R6 still halted", d, stat(1, 0, 0));
        unl_write(5'h04, 32'h1_0000);
        chk("R10 irq cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_closed();
        logic [31:0] d;
        int base;
        unl_write(5'h0C, 32'd40);
        unl_write(5'h10, 32'd20);
        base = rst_seen;
        unl_write(5'h04, 32'h1);
        unl_write(5'h04, 32'h0);
        bus_read(5'h04, d);  chk("R7 stop ignored when closed", d, stat(0, 0, 1));
        unl_write(5'h0C, 32'd3);
        bus_read(5'h0C, d);  chk("R7 closed len frozen", d, 32'd40);
        unl_write(5'h10, 32'd99);
        bus_read(5'h10, d);  chk("R7 open len frozen", d, 32'd20);
        tick(40);
        bus_read(5'h04, d);  chk("R5 open reached", d, stat(1, 1, 1));
        unl_write(5'h04, 32'h1_0000);
        bus_read(5'h04, d);  chk("R9 stopped in open", d, stat(0, 0, 0));
        tick(40);
        chk("R9 no pulse after stop", 32'(rst_seen - base), 32'd0);
    endtask

    task automatic t_refresh();
        logic [31:0] d;
        int base;
        unl_write(5'h0C, 32'd3);
        unl_write(5'h10, 32'd30);
        base = rst_seen;
        unl_write(5'h04, 32'h1);
        tick(4);
        bus_read(5'h04, d);  chk("R5 open after 4", d, stat(1, 1, 1));
        unl_write(5'h04, 32'h101);
        bus_read(5'h04, d);  chk("R12 unarmed refresh ignored", d, stat(1, 1, 1));
        unl_write(5'h04, 32'h1_0001);
        bus_read(5'h04, d);  chk("R8 armed, irq cleared", d, stat(0, 1, 1));
        unl_write(5'h04, 32'h101);
        bus_read(5'h04, d);  chk("R8 restarted closed", d, stat(0, 0, 1));
        tick(3);
        bus_read(5'h04, d);  chk("R8 closed holds N cycles", d, stat(0, 0, 1));
        tick(1);
        bus_read(5'h04, d);  chk("R8 open again", d, stat(1, 1, 1));
        unl_write(5'h04, 32'h1_0000);
        bus_read(5'h04, d);  chk("R9 stop after refresh", d, stat(0, 0, 0));
        chk("R8 no pulse during refresh", 32'(rst_seen - base), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_gating();
        t_expire();
        t_closed();
        t_refresh();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule